// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Scan Controller

This block sequences conversions over eight analog inputs that share one multiplexer and one successive-approximation converter. For each enabled input it drives the multiplexer select and runs a binary search on a DAC code, using a single comparator bit from the analog side. It stores the outcome in a result register for that input. Each result is then compared with a threshold for that input, and a less-than flag is recorded. The DAC, the multiplexer and the comparator are outside the block. The block only sees them through `dac_code`, `ch_sel` and `comp_in`.

Software sets up the block through a small word-addressed register port. The settings are an enable mask, a resolution from 2 to 10 bits, single or repeating scans, a trigger source and a power-down bit. Software can also write a start command. A scan can instead begin on a rising edge of one selected event line: an external pin, a timer event, a PWM synchronisation pulse, or the end-of-scan of a neighbouring converter. Each finished scan gives a one-cycle `scan_done` pulse. This pulse can feed the neighbour input of another converter of the same kind.

Register map (word addresses). CTRL at 0: enable mask in bits 7:0, resolution in 11:8, repeat bit 12, trigger source in 18:16, power-down bit 20. START at 1: writing bit 0 as 1 requests a scan, and the register reads as zero. MATCH at 2: sticky threshold status in bits 7:0, cleared by writing 1. THRESH at 8+n: threshold for input n in bits 9:0. RESULT at 16+n: result in bits 9:0 and the less-than flag in bit 16. Trigger source codes: 0 software only, 1 pin, 2 timer, 3 PWM sync, 4 neighbour, 5 to 7 software only.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, every register reads zero, `busy`, `scan_done`, `ch_sel` and `dac_code` are zero, and no scan runs.
- R2: A conversion at resolution N runs from the MSB down, with one trial bit per clock cycle. A trial bit is kept when `comp_in` is 1 in the cycle after that code was driven. The stored result is the input value with its low 10-N bits cleared, left-aligned in 10 bits.
- R3: Resolution values below 2 act as 2 and values above 10 act as 10. Each extra bit of resolution lengthens every conversion by exactly one clock cycle.
- R4: A single scan converts each enabled input once, in ascending index order, with `ch_sel` held for the whole conversion. It then goes idle, and `scan_done` is high for exactly one cycle.
- R5: With the repeat bit (CTRL bit 12) set, a new scan starts from the lowest enabled input after each `scan_done`. Clearing the bit lets the current scan finish and then the block goes idle.
- R6: Writing 1 to START bit 0 starts a scan from idle whatever the trigger source. A start with an all-zero enable mask is ignored.
- R7: Only a rising edge on the line picked by the trigger source code starts a scan. Holding the line high starts one scan only. Edges on the other lines have no effect.
- R8: A start request or trigger edge that arrives while a scan is running has no effect.
- R9: Each RESULT register keeps the latest result of its input. Inputs that are not enabled keep their previous value.
- R10: The less-than flag (RESULT bit 16) is 1 when the latest result is below the input's threshold, and 0 when it is equal or greater.
- R11: At the end of each scan, MATCH bit n is set for every input n converted in that scan whose result was equal to or greater than its threshold. A set bit stays set until software writes 1 to it.
- R12: With power-down (CTRL bit 20) set, a running scan is abandoned within one cycle, `dac_code` returns to zero, and no start request or trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| ext_start | input | 1 | External start pin event line |
| timer_evt | input | 1 | Timer capture/match event line |
| pwm_sync | input | 1 | PWM synchronisation event line |
| peer_eos | input | 1 | End-of-scan from a neighbouring converter |
| comp_in | input | 1 | Comparator: 1 when the selected input is at or above the DAC level |
| ch_sel | output | 3 | Analog multiplexer select |
| dac_code | output | 10 | Trial code for the DAC |
| scan_done | output | 1 | One-cycle pulse at the end of each scan |
| busy | output | 1 | A scan is in progress |

## Verification
The hardest cases to reach from the ports are a trigger edge arriving in the middle of a long scan, and power-down applied partway through a conversion. The bench starts a full eight-input scan at 10-bit resolution, then sends a second pin edge or sets power-down a few cycles in. It then counts `scan_done` pulses and watches `busy` and `dac_code`. To check the bit-by-bit search, a comparator model in the bench answers from its own table of analog values. Timing effects of resolution are measured as differences in scan length, so they do not depend on fixed pipeline latency.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int NCH_DEFAULT  = 8;
    localparam int RES_DEFAULT  = 10;
    localparam int RES_MIN      = 2;
    localparam int RES_FIELD_W  = 4;
    localparam int ADDR_W_DEF   = 5;
    localparam int DATA_W_DEF   = 32;

    // Register word addresses
    localparam int ADR_CTRL     = 0;
    localparam int ADR_START    = 1;
    localparam int ADR_MATCH    = 2;
    localparam int ADR_THR_BASE = 8;
    localparam int ADR_RES_BASE = 16;

    // CTRL field positions
    localparam int CTRL_RES_LSB = 8;
    localparam int CTRL_REP_BIT = 12;
    localparam int CTRL_SRC_LSB = 16;
    localparam int CTRL_PD_BIT  = 20;
    localparam int RES_LT_BIT   = 16;

    typedef enum logic [2:0] {
        TRG_SOFT  = 3'd0,
        TRG_PIN   = 3'd1,
        TRG_TIMER = 3'd2,
        TRG_PWM   = 3'd3,
        TRG_PEER  = 3'd4
    } trig_src_e;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_CONV = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic                   pd;
        trig_src_e              src;
        logic                   repeat_en;
        logic [RES_FIELD_W-1:0] res;
    } scan_cfg_t;

    function automatic logic [RES_FIELD_W-1:0] clamp_res(
        input logic [RES_FIELD_W-1:0] r, input int rmax);
        if (int'(r) < RES_MIN) return RES_FIELD_W'(RES_MIN);
        if (int'(r) > rmax)    return RES_FIELD_W'(rmax);
        return r;
    endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_src_e src,
    input  logic      pin_line,
    input  logic      tmr_line,
    input  logic      pwm_line,
    input  logic      peer_line,
    output logic      evt
);
    localparam int NLINE = 4;

    logic [NLINE-1:0] lines, prev_q, rise;
    logic             pick;

    assign lines = {peer_line, pwm_line, tmr_line, pin_line};
    assign rise  = lines & ~prev_q;

    always_comb begin
        case (src)
            TRG_PIN:   pick = rise[0];
            TRG_TIMER: pick = rise[1];
            TRG_PWM:   pick = rise[2];
            TRG_PEER:  pick = rise[3];
            default:   pick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            evt    <= 1'b0;
        end else begin
            prev_q <= lines;
            evt    <= pick;
        end
    end
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
    import adc_scan_pkg::*;
#(
    parameter int RES_MAX = RES_DEFAULT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic                   abort,
    input  logic [RES_FIELD_W-1:0] res_bits,
    input  logic                   comp_in,
    output logic [RES_MAX-1:0]     dac_code,
    output logic                   done,
    output logic [RES_MAX-1:0]     result
);
    localparam int IDX_W = $clog2(RES_MAX);
    localparam logic [RES_MAX-1:0] ONE = RES_MAX'(1);

    logic             active;
    logic [IDX_W-1:0] idx_q, stop_q;
    logic [RES_MAX-1:0] kept;

    // Drop the current trial bit if the input is below the trial level
    assign kept = comp_in ? dac_code : (dac_code & ~(ONE << idx_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            dac_code <= '0;
            idx_q    <= '0;
            stop_q   <= '0;
            done     <= 1'b0;
            result   <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                active   <= 1'b0;
                dac_code <= '0;
            end else if (go) begin
                active   <= 1'b1;
                dac_code <= ONE << (RES_MAX - 1);
                idx_q    <= IDX_W'(RES_MAX - 1);
                stop_q   <= IDX_W'(RES_MAX - int'(res_bits));
            end else if (active) begin
                if (idx_q == stop_q) begin
                    result   <= kept;
                    done     <= 1'b1;
                    active   <= 1'b0;
                    dac_code <= '0;
                end else begin
                    dac_code <= kept | (ONE << (idx_q - 1'b1));
                    idx_q    <= idx_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_ch_finder.sv
module adc_ch_finder #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CH_W-1:0]   cur,
    output logic              first_vld,
    output logic [CH_W-1:0]   first_idx,
    output logic              next_vld,
    output logic [CH_W-1:0]   next_idx
);
    always_comb begin
        first_vld = 1'b0;
        first_idx = '0;
        next_vld  = 1'b0;
        next_idx  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                first_vld = 1'b1;
                first_idx = CH_W'(i);
                if (i > int'(cur)) begin
                    next_vld = 1'b1;
                    next_idx = CH_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = NCH_DEFAULT,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pd,
    input  logic              repeat_en,
    input  logic [NUM_CH-1:0] mask,
    input  logic              eng_done,
    output logic              go,
    output logic [CH_W-1:0]   ch,
    output logic              busy,
    output logic              conv_wr,
    output logic              scan_end,
    output logic              scan_done
);
    seq_state_e      state_q;
    logic            first_vld, next_vld;
    logic [CH_W-1:0] first_idx, next_idx;

    adc_ch_finder #(.NUM_CH(NUM_CH)) finder_i (
        .mask      (mask),
        .cur       (ch),
        .first_vld (first_vld),
        .first_idx (first_idx),
        .next_vld  (next_vld),
        .next_idx  (next_idx)
    );

    assign busy     = (state_q == SQ_CONV);
    assign conv_wr  = busy && eng_done && !pd;
    assign scan_end = conv_wr && !next_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            ch        <= '0;
            go        <= 1'b0;
            scan_done <= 1'b0;
        end else begin
            go        <= 1'b0;
            scan_done <= scan_end;
            case (state_q)
                SQ_IDLE: begin
                    if (start && !pd && first_vld) begin
                        ch      <= first_idx;
                        go      <= 1'b1;
                        state_q <= SQ_CONV;
                    end
                end
                default: begin
                    if (pd) begin
                        state_q <= SQ_IDLE;
                    end else if (eng_done) begin
                        if (next_vld) begin
                            ch <= next_idx;
                            go <= 1'b1;
                        end else if (repeat_en && first_vld) begin
                            ch <= first_idx;
                            go <= 1'b1;
                        end else begin
                            state_q <= SQ_IDLE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NUM_CH  = 8,
    parameter int RES_MAX = 10,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            thr_we,
    input  logic [CH_W-1:0]                 thr_idx,
    input  logic [RES_MAX-1:0]              thr_val,
    input  logic                            conv_wr,
    input  logic [CH_W-1:0]                 conv_ch,
    input  logic [RES_MAX-1:0]              conv_val,
    input  logic                            scan_end,
    input  logic                            abort,
    input  logic [NUM_CH-1:0]               clr_mask,
    output logic [NUM_CH-1:0][RES_MAX-1:0]  results,
    output logic [NUM_CH-1:0][RES_MAX-1:0]  thresholds,
    output logic [NUM_CH-1:0]               lt_flags,
    output logic [NUM_CH-1:0]               match_sts
);
    logic [NUM_CH-1:0] pend_q, pend_set;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit         = conv_wr && (conv_ch == CH_W'(g));
        assign pend_set[g] = hit && (conv_val >= thresholds[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                results[g]    <= '0;
                thresholds[g] <= '0;
                lt_flags[g]   <= 1'b0;
            end else begin
                if (thr_we && thr_idx == CH_W'(g)) thresholds[g] <= thr_val;
                if (hit) begin
                    results[g]  <= conv_val;
                    lt_flags[g] <= (conv_val < thresholds[g]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            match_sts <= '0;
        end else begin
            pend_q    <= (scan_end || abort) ? '0 : (pend_q | pend_set);
            match_sts <= (match_sts & ~clr_mask) | (scan_end ? (pend_q | pend_set) : '0);
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH  = NCH_DEFAULT,
    parameter int RES_MAX = RES_DEFAULT,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               ext_start,
    input  logic               timer_evt,
    input  logic               pwm_sync,
    input  logic               peer_eos,
    input  logic               comp_in,
    output logic [CH_W-1:0]    ch_sel,
    output logic [RES_MAX-1:0] dac_code,
    output logic               scan_done,
    output logic               busy
);
    scan_cfg_t                          cfg_q;
    logic [NUM_CH-1:0]                  mask_q;
    logic                               pd_w, sw_start, trig_evt, start_req;
    logic                               go, eng_done, conv_wr, scan_end;
    logic [RES_MAX-1:0]                 eng_result;
    logic                               thr_we;
    logic [CH_W-1:0]                    thr_idx;
    logic [NUM_CH-1:0]                  clr_mask;
    logic [NUM_CH-1:0][RES_MAX-1:0]     results, thresholds;
    logic [NUM_CH-1:0]                  lt_flags, match_sts;
    logic                               unused_wdata;

    assign unused_wdata = ^wr_data;
    assign pd_w      = cfg_q.pd;
    assign sw_start  = wr_en && (wr_addr == ADDR_W'(ADR_START)) && wr_data[0];
    assign start_req = sw_start || trig_evt;
    assign clr_mask  = (wr_en && wr_addr == ADDR_W'(ADR_MATCH)) ? wr_data[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(ADR_CTRL)) begin
            mask_q          <= wr_data[NUM_CH-1:0];
            cfg_q.res       <= wr_data[CTRL_RES_LSB +: RES_FIELD_W];
            cfg_q.repeat_en <= wr_data[CTRL_REP_BIT];
            cfg_q.src       <= trig_src_e'(wr_data[CTRL_SRC_LSB +: 3]);
            cfg_q.pd        <= wr_data[CTRL_PD_BIT];
        end
    end

    always_comb begin
        thr_we  = 1'b0;
        thr_idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en && wr_addr == ADDR_W'(ADR_THR_BASE + i)) begin
                thr_we  = 1'b1;
                thr_idx = CH_W'(i);
            end
        end
    end

    adc_trig_sel trig_i (
        .clk       (clk),
        .rst       (rst),
        .src       (cfg_q.src),
        .pin_line  (ext_start),
        .tmr_line  (timer_evt),
        .pwm_line  (pwm_sync),
        .peer_line (peer_eos),
        .evt       (trig_evt)
    );

    adc_scan_seq #(.NUM_CH(NUM_CH)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start_req),
        .pd        (pd_w),
        .repeat_en (cfg_q.repeat_en),
        .mask      (mask_q),
        .eng_done  (eng_done),
        .go        (go),
        .ch        (ch_sel),
        .busy      (busy),
        .conv_wr   (conv_wr),
        .scan_end  (scan_end),
        .scan_done (scan_done)
    );

    adc_sar_engine #(.RES_MAX(RES_MAX)) sar_i (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .abort    (pd_w),
        .res_bits (clamp_res(cfg_q.res, RES_MAX)),
        .comp_in  (comp_in),
        .dac_code (dac_code),
        .done     (eng_done),
        .result   (eng_result)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .RES_MAX(RES_MAX)) bank_i (
        .clk        (clk),
        .rst        (rst),
        .thr_we     (thr_we),
        .thr_idx    (thr_idx),
        .thr_val    (wr_data[RES_MAX-1:0]),
        .conv_wr    (conv_wr),
        .conv_ch    (ch_sel),
        .conv_val   (eng_result),
        .scan_end   (scan_end),
        .abort      (pd_w),
        .clr_mask   (clr_mask),
        .results    (results),
        .thresholds (thresholds),
        .lt_flags   (lt_flags),
        .match_sts  (match_sts)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_CTRL)) begin
            rd_data[NUM_CH-1:0]                  = mask_q;
            rd_data[CTRL_RES_LSB +: RES_FIELD_W] = cfg_q.res;
            rd_data[CTRL_REP_BIT]                = cfg_q.repeat_en;
            rd_data[CTRL_SRC_LSB +: 3]           = cfg_q.src;
            rd_data[CTRL_PD_BIT]                 = cfg_q.pd;
        end else if (rd_addr == ADDR_W'(ADR_MATCH)) begin
            rd_data[NUM_CH-1:0] = match_sts;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(ADR_THR_BASE + i)) begin
                rd_data[RES_MAX-1:0] = thresholds[i];
            end
            if (rd_addr == ADDR_W'(ADR_RES_BASE + i)) begin
                rd_data[RES_MAX-1:0] = results[i];
                rd_data[RES_LT_BIT]  = lt_flags[i];
            end
        end
    end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH  = NCH_DEFAULT,
    parameter int RES_MAX = RES_DEFAULT,
    parameter int ADDR_W  = ADDR_W_DEF,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input logic               clk,
    input logic               rst,
    input logic               pd,
    input logic               busy,
    input logic               scan_done,
    input logic               eng_done,
    input logic [CH_W-1:0]    ch_sel,
    input logic [RES_MAX-1:0] dac_code,
    input logic [NUM_CH-1:0]  match_sts,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr
);
    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == ADDR_W'(ADR_MATCH));

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done);                                     // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> $past(busy));                                    // R4
    AST_CHSEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !eng_done) |=> $stable(ch_sel));                      // R4
    AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dac_code == '0));                                   // R12
    AST_PD_STOPS_SCAN: assert property (@(posedge clk) disable iff (rst)
        pd |=> !busy);                                                 // R12
    AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((match_sts & $past(match_sts)) == $past(match_sts))); // R11
endmodule

bind adc_scan_ctrl adc_scan_chk #(
    .NUM_CH(NUM_CH), .RES_MAX(RES_MAX), .ADDR_W(ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pd        (pd_w),
    .busy      (busy),
    .scan_done (scan_done),
    .eng_done  (eng_done),
    .ch_sel    (ch_sel),
    .dac_code  (dac_code),
    .match_sts (match_sts),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr)
);

// File: tb/adc_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ext_start = 1'b0, timer_evt = 1'b0, pwm_sync = 1'b0, peer_eos = 1'b0;
    logic        comp_in;
    logic [2:0]  ch_sel;
    logic [9:0]  dac_code;
    logic        scan_done, busy;

    logic [9:0]  ain [8];
    int          n_checks = 0, n_fail = 0, done_cnt = 0, cyc = 0;
    int          ord [16];
    int          ord_n = 0;
    logic        prev_busy_m = 1'b0;
    logic [2:0]  prev_ch_m = '0;
    bit          finished = 0;

    always #2 clk = ~clk;

    assign comp_in = (ain[ch_sel] >= dac_code);

    adc_scan_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_start(ext_start), .timer_evt(timer_evt),
        .pwm_sync(pwm_sync), .peer_eos(peer_eos), .comp_in(comp_in), .ch_sel(ch_sel),
        .dac_code(dac_code), .scan_done(scan_done), .busy(busy)
    );

    always @(negedge clk) begin
        if (scan_done) done_cnt++;
        if (busy && (!prev_busy_m || ch_sel != prev_ch_m) && ord_n < 16) begin
            ord[ord_n] = int'(ch_sel);
            ord_n++;
        end
        prev_busy_m = busy;
        prev_ch_m   = ch_sel;
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl(input int mask, input int res, input bit rep,
                                         input int src, input bit pd);
        logic [31:0] v = '0;
        v[7:0] = mask[7:0]; v[11:8] = res[3:0]; v[12] = rep; v[18:16] = src[2:0]; v[20] = pd;
        return v;
    endfunction

    function automatic int trunc(input int v, input int n);
        return (v >> (10 - n)) << (10 - n);
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a[4:0]; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); rd_addr = a[4:0]; #1; d = rd_data;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!scan_done && n < 5000);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(busy == 0 && scan_done == 0, "R1 busy/done", {busy, scan_done}, 0);
        check(dac_code == 0 && ch_sel == 0, "R1 dac/ch", {dac_code, ch_sel}, 0);
        rd(0, d); check(d == 0, "R1 ctrl", d, 0);
        rd(2, d); check(d == 0, "R1 match", d, 0);
        for (int i = 0; i < 8; i++) begin
            rd(16 + i, d); check(d == 0, "R1 result", d, 0);
        end
    endtask

    task automatic t_single();
        logic [31:0] d;
        int n;
        int exp_ord [4] = '{0, 2, 5, 7};
        ain[0] = 10'h3FF; ain[2] = 10'h000; ain[5] = 10'h155; ain[7] = 10'h200;
        ain[1] = 10'h111; ain[3] = 10'h222; ain[4] = 10'h333; ain[6] = 10'h0AA;
        wr(0, ctrl(8'hA5, 10, 0, 0, 0));
        ord_n = 0;
        wr(1, 32'h1);
        wait_done(n);
        check(n < 5000, "R4 scan finished", n, 0);
        @(negedge clk);
        check(scan_done == 0, "R4 done one cycle", scan_done, 0);
        idle(3);
        check(busy == 0, "R4 idle after single scan", busy, 0);
        check(ord_n == 4, "R4 conversion count", ord_n, 4);
        for (int i = 0; i < 4; i++) check(ord[i] == exp_ord[i], "R4 order", ord[i], exp_ord[i]);
        for (int i = 0; i < 8; i++) begin
            int e;
            rd(16 + i, d);
            e = ((8'hA5 >> i) & 1) != 0 ? int'(ain[i]) : 0;
            check(int'(d[9:0]) == e, "R2 R9 result", d[9:0], e);
        end
    endtask

    task automatic t_resolution();
        logic [31:0] d;
        int n2, n10, n0, n15, n6;
        ain[0] = 10'h2FF;
        wr(0, ctrl(1, 2, 0, 0, 0));  wr(1, 1); wait_done(n2);
        rd(16, d); check(int'(d[9:0]) == trunc(10'h2FF, 2), "R2 res2 value", d[9:0], trunc(10'h2FF, 2));
        wr(0, ctrl(1, 6, 0, 0, 0));  wr(1, 1); wait_done(n6);
        rd(16, d); check(int'(d[9:0]) == trunc(10'h2FF, 6), "R2 res6 value", d[9:0], trunc(10'h2FF, 6));
        wr(0, ctrl(1, 10, 0, 0, 0)); wr(1, 1); wait_done(n10);
        rd(16, d); check(int'(d[9:0]) == 10'h2FF, "R2 res10 value", d[9:0], 10'h2FF);
        wr(0, ctrl(1, 0, 0, 0, 0));  wr(1, 1); wait_done(n0);
        rd(16, d); check(int'(d[9:0]) == trunc(10'h2FF, 2), "R3 clamp low value", d[9:0], trunc(10'h2FF, 2));
        wr(0, ctrl(1, 15, 0, 0, 0)); wr(1, 1); wait_done(n15);
        rd(16, d); check(int'(d[9:0]) == 10'h2FF, "R3 clamp high value", d[9:0], 10'h2FF);
        check(n10 - n2 == 8, "R3 cycles per bit", n10 - n2, 8);
        check(n6 - n2 == 4, "R3 cycles per bit mid", n6 - n2, 4);
        check(n0 == n2, "R3 clamp low timing", n0, n2);
        check(n15 == n10, "R3 clamp high timing", n15, n10);
    endtask

    task automatic t_compare();
        logic [31:0] d;
        int n;
        int thr [4] = '{150, 200, 299, 1023};
        int exp_lt [4] = '{1, 0, 0, 1};
        ain[0] = 10'd100; ain[1] = 10'd200; ain[2] = 10'd300; ain[3] = 10'd400;
        for (int i = 0; i < 4; i++) wr(8 + i, thr[i]);
        wr(2, 32'hFF);
        rd(2, d); check(d == 0, "R11 clear all", d, 0);
        wr(0, ctrl(8'h0F, 10, 0, 0, 0));
        wr(1, 1); wait_done(n);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            rd(16 + i, d); check(int'(d[16]) == exp_lt[i], "R10 less-than flag", d[16], exp_lt[i]);
        end
        rd(2, d); check(d == 32'h06, "R11 match set at scan end", d, 32'h06);
        wr(2, 32'h02);
        rd(2, d); check(d == 32'h04, "R11 write-one clear", d, 32'h04);
        wr(2, 32'hFF);
    endtask

    task automatic t_repeat();
        logic [31:0] d;
        int n;
        ain[0] = 10'h100; ain[1] = 10'h080;
        wr(0, ctrl(8'h03, 10, 1, 0, 0));
        wr(1, 1); wait_done(n);
        ain[0] = 10'h300;
        @(negedge clk);
        check(busy == 1, "R5 restarted", busy, 1);
        wait_done(n); wait_done(n);
        rd(16, d); check(int'(d[9:0]) == 10'h300, "R5 new value converted", d[9:0], 10'h300);
        wr(0, ctrl(8'h03, 10, 0, 0, 0));
        wait_done(n); idle(4);
        check(busy == 0, "R5 stops after repeat cleared", busy, 0);
    endtask

    task automatic t_triggers();
        int c0;
        wr(0, ctrl(1, 2, 0, 1, 0));
        c0 = done_cnt;
        @(negedge clk); ext_start = 1'b1; idle(40);
        check(done_cnt - c0 == 1, "R7 level gives one scan", done_cnt - c0, 1);
        ext_start = 1'b0;
        @(negedge clk); timer_evt = 1'b1; @(negedge clk); timer_evt = 1'b0;
        pwm_sync = 1'b1; @(negedge clk); pwm_sync = 1'b0; idle(20);
        check(done_cnt - c0 == 1 && busy == 0, "R7 unselected lines ignored", done_cnt - c0, 1);
        wr(0, ctrl(1, 2, 0, 2, 0));
        @(negedge clk); timer_evt = 1'b1; @(negedge clk); timer_evt = 1'b0; idle(20);
        check(done_cnt - c0 == 2, "R7 timer source", done_cnt - c0, 2);
        wr(0, ctrl(1, 2, 0, 3, 0));
        @(negedge clk); pwm_sync = 1'b1; @(negedge clk); pwm_sync = 1'b0; idle(20);
        check(done_cnt - c0 == 3, "R7 pwm source", done_cnt - c0, 3);
        wr(0, ctrl(1, 2, 0, 4, 0));
        @(negedge clk); peer_eos = 1'b1; @(negedge clk); peer_eos = 1'b0; idle(20);
        check(done_cnt - c0 == 4, "R7 peer source", done_cnt - c0, 4);
        wr(1, 1); idle(20);
        check(done_cnt - c0 == 5, "R6 software start with trigger source", done_cnt - c0, 5);
    endtask

    task automatic t_busy_ignore();
        int c0;
        wr(0, ctrl(8'hFF, 10, 0, 1, 0));
        c0 = done_cnt;
        @(negedge clk); ext_start = 1'b1; @(negedge clk); ext_start = 1'b0;
        idle(10);
        check(busy == 1, "R8 long scan running", busy, 1);
        ext_start = 1'b1; @(negedge clk); ext_start = 1'b0;
        wr(1, 1);
        idle(250);
        check(done_cnt - c0 == 1 && busy == 0, "R8 start while busy ignored", done_cnt - c0, 1);
    endtask

    task automatic t_powerdown();
        int c0;
        wr(0, ctrl(8'hFF, 10, 0, 0, 0));
        c0 = done_cnt;
        wr(1, 1); idle(15);
        wr(0, ctrl(8'hFF, 10, 0, 0, 1));
        @(negedge clk);
        check(busy == 0 && dac_code == 0, "R12 scan abandoned", {busy, dac_code}, 0);
        wr(1, 1); idle(30);
        check(busy == 0 && done_cnt == c0, "R12 start blocked", done_cnt - c0, 0);
        wr(0, ctrl(8'h00, 10, 0, 0, 0));
        wr(1, 1); idle(20);
        check(busy == 0 && done_cnt == c0, "R6 empty mask ignored", done_cnt - c0, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) ain[i] = '0;
        idle(5);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_single();
        t_resolution();
        t_compare();
        t_repeat();
        t_triggers();
        t_busy_ignore();
        t_powerdown();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule